// File: doc/BRIEF.md
# Two-Port Pin Event Interrupt Controller

This block watches a bank of GPIO input lines, grouped into ports of sixteen pins, and latches a sticky flag on any line whose trigger condition occurs. Each line chooses edge or level detection, a polarity, and an option to catch both transitions. The trigger cannot be turned off, so flags keep latching even while a line is masked. Software therefore clears a line's flag after it reconfigures the line and before it enables the line's interrupt.

Each port drives one interrupt output. It is high while any line of that port has both its flag and its enable set. Software reaches the configuration, enable and flag registers through a single-cycle register port. A write takes effect at the clock edge it is sampled on. Read data is combinational from the address. The register port has no handshake and can never stall: it is control traffic, not a stream, so it has no valid/ready pair and no back-pressure.

Top module: `pin_event_irq_ctrl`

## Requirements
- R1: Line n is bit n of `pins_i` and of every register. Bit 4 of the line index selects the port and bits 3:0 select the pin. `irq_o[0]` covers lines 0 to 15 and `irq_o[1]` covers lines 16 to 31.
- R2: Every pin passes through a two-flop synchroniser. After a pin change, the flag becomes visible on the third rising clock edge, and not before.
- R3: In edge mode (mode bit = 1, both bit = 0) with polarity = 1, a 0-to-1 transition sets the line's flag.
- R4: In edge mode with polarity = 0, a 1-to-0 transition sets the flag and a 0-to-1 transition does not.
- R5: In edge mode with both bit = 1, either transition sets the flag, whatever the polarity bit holds.
- R6: In level mode (mode bit = 0), the flag is set on every clock while the pin equals the polarity bit. A clear has no lasting effect while that level persists.
- R7: A flag latches whether or not the line's interrupt enable is set.
- R8: `irq_o[p]` is high exactly when some line of port p has both its flag and its enable bit set.
- R9: Writing 1 to a bit of the flag register (address 4) clears that flag. Writing 0 leaves the flag unchanged.
- R10: If a trigger event and a clearing write hit the same line in the same cycle, the flag ends up set.
- R11: The register map is: address 0 mode, address 1 both-edge, address 2 polarity, address 3 enable, address 4 flags. All registers reset to zero and read back their contents. Addresses 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous GPIO inputs, line n on bit n |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| irq_o | output | 2 | One interrupt request per port |

## Verification
The bench targets the synchroniser latency. A design with one stage too few or too many shows the flag a cycle early or late. It also targets the case where polarity is set against the direction of travel: a wrong polarity decode flags the rise instead of the fall. Both-edge mode is run with a polarity that would otherwise block the transition, which exposes an override that was not applied. The bench also checks that a clear does not stick while an active level holds, and that a clear landing in the same cycle as a new edge does not drop that edge. Port mapping is tested by setting flags on lines in different ports, so a swapped interrupt output is detected. A random phase writes every address, including the unmapped ones, and compares outputs against the model on every cycle.

// File: rtl/pgi_pkg.sv
package pgi_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MODE = 3'd0,
    SEL_BOTH = 3'd1,
    SEL_POL  = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_FLAG = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic edge_mode;
    logic both;
    logic pol;
  } line_cfg_t;
endpackage

// File: rtl/pgi_sync.sv
module pgi_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  logic [1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= '0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == 2'd2) |-> (sync_o == $past(din_i, 2))); // R2
  end
endmodule

// File: rtl/pgi_trigger.sv
module pgi_trigger
  import pgi_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] level_i,
  input  logic [LINES-1:0] mode_i,
  input  logic [LINES-1:0] both_i,
  input  logic [LINES-1:0] pol_i,
  output logic [LINES-1:0] event_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    line_cfg_t cfg;
    logic      rise, fall, edge_hit, lvl_hit;

    assign cfg      = '{edge_mode: mode_i[n], both: both_i[n], pol: pol_i[n]};
    assign rise     = level_i[n] & ~prev_q[n];
    assign fall     = ~level_i[n] & prev_q[n];
    assign edge_hit = cfg.both ? (rise | fall) : (cfg.pol ? rise : fall);
    assign lvl_hit  = cfg.pol ? level_i[n] : ~level_i[n];
    assign event_o[n] = cfg.edge_mode ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/pgi_regs.sv
module pgi_regs
  import pgi_pkg::*;
#(
  parameter int unsigned PORTS = 2,
  parameter int unsigned PINS  = 16,
  localparam int unsigned LINES = PORTS * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [LINES-1:0]  event_i,
  output logic [LINES-1:0]  mode_o,
  output logic [LINES-1:0]  both_o,
  output logic [LINES-1:0]  pol_o,
  output logic [LINES-1:0]  ien_o,
  output logic [LINES-1:0]  flag_o,
  output logic [LINES-1:0]  rdata_o,
  output logic [PORTS-1:0]  irq_o
);
  logic [LINES-1:0] mode_q, both_q, pol_q, ien_q, flag_q, clr_vec;
  reg_sel_e sel;

  assign sel     = reg_sel_e'(addr_i);
  assign clr_vec = (wr_i && sel == SEL_FLAG) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_MODE: mode_q <= wdata_i;
        SEL_BOTH: both_q <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        SEL_IEN:  ien_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | event_i;
  end

  always_comb begin
    case (sel)
      SEL_MODE: rdata_o = mode_q;
      SEL_BOTH: rdata_o = both_q;
      SEL_POL:  rdata_o = pol_q;
      SEL_IEN:  rdata_o = ien_q;
      SEL_FLAG: rdata_o = flag_q;
      default:  rdata_o = '0;
    endcase
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign irq_o[p] = |(flag_q[p*PINS +: PINS] & ien_q[p*PINS +: PINS]);
  end

  assign mode_o = mode_q;
  assign both_o = both_q;
  assign pol_o  = pol_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;

  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> ((($past(flag_q) & ~$past(clr_vec)) & ~flag_q) == '0)); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (($past(event_i) & ~flag_q) == '0)); // R10
endmodule

// File: rtl/pin_event_irq_ctrl.sv
module pin_event_irq_ctrl
  import pgi_pkg::*;
#(
  parameter int unsigned PORTS       = 2,
  parameter int unsigned PINS        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LINES = PORTS * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pins_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [LINES-1:0]  cfg_wdata_i,
  output logic [LINES-1:0]  cfg_rdata_o,
  output logic [PORTS-1:0]  irq_o
);
  logic [LINES-1:0] sync_w, event_w, mode_w, both_w, pol_w, ien_w, flag_w;

  pgi_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (pins_i),
    .sync_o (sync_w)
  );

  pgi_trigger #(.LINES(LINES)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sync_w),
    .mode_i  (mode_w),
    .both_i  (both_w),
    .pol_i   (pol_w),
    .event_o (event_w)
  );

  pgi_regs #(.PORTS(PORTS), .PINS(PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cfg_wr_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .event_i (event_w),
    .mode_o  (mode_w),
    .both_o  (both_w),
    .pol_o   (pol_w),
    .ien_o   (ien_w),
    .flag_o  (flag_w),
    .rdata_o (cfg_rdata_o),
    .irq_o   (irq_o)
  );

  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_w == '0) |-> (irq_o == '0)); // R8
  AST_BOTH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (((mode_w & both_w & (sync_w ^ $past(sync_w))) & ~event_w) == '0)); // R5
  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (($past(~mode_w & ~(sync_w ^ pol_w)) & ~flag_w) == '0)); // R6
endmodule

// File: tb/pin_event_irq_ctrl_tb.sv
module pin_event_irq_ctrl_tb;
  localparam int  N       = 32;
  localparam time CLK_PER = 10ns;
  localparam int  WD_MAX  = 50000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         cfg_wr = 1'b0;
  logic [2:0]   cfg_addr = 3'd0;
  logic [N-1:0] cfg_wdata = '0;
  logic [N-1:0] cfg_rdata;
  logic [1:0]   irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  pin_event_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_wr_i(cfg_wr),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .irq_o(irq)
  );

  // behavioural reference state
  logic [N-1:0] m_s1, m_s2, m_prev, m_mode, m_both, m_pol, m_en, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
      m_mode <= '0; m_both <= '0; m_pol <= '0; m_en <= '0; m_flag <= '0;
    end else begin
      logic [N-1:0] ev, clr;
      for (int i = 0; i < N; i++) begin
        bit rise, fall;
        rise = m_s2[i] && !m_prev[i];
        fall = !m_s2[i] && m_prev[i];
        if (!m_mode[i])     ev[i] = (m_s2[i] == m_pol[i]);
        else if (m_both[i]) ev[i] = rise || fall;
        else if (m_pol[i])  ev[i] = rise;
        else                ev[i] = fall;
      end
      clr = (cfg_wr && cfg_addr == 3'd4) ? cfg_wdata : '0;
      m_flag <= (m_flag & ~clr) | ev;
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      if (cfg_wr) begin
        case (cfg_addr)
          3'd0: m_mode <= cfg_wdata;
          3'd1: m_both <= cfg_wdata;
          3'd2: m_pol  <= cfg_wdata;
          3'd3: m_en   <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_both;
      3'd2: return m_pol;
      3'd3: return m_en;
      3'd4: return m_flag;
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] m_irq();
    logic [1:0] r;
    for (int p = 0; p < 2; p++) r[p] = |(m_flag[p*16 +: 16] & m_en[p*16 +: 16]);
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(irq == m_irq(), "R8 irq per port vs model", 32'(irq), 32'(m_irq()));
    chk(cfg_rdata == m_read(cfg_addr), "R11 readback vs model", cfg_rdata, m_read(cfg_addr));
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [N-1:0] exp, string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected<=%0d", cyc, WD_MAX);
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R11: reset values
    for (int a = 0; a < 8; a++) rd(3'(a), '0, "R11 reset value");
    chk(irq == 2'b00, "R11 reset irq", 32'(irq), 0);
    rst_n = 1'b1;
    steps(2);
    // R6/R7: default level-low mode latches all flags while masked
    rd(3'd4, 32'hFFFF_FFFF, "R6 default low level latches");
    chk(irq == 2'b00, "R7 flags latch while masked", 32'(irq), 0);

    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, '0, "R9 clear all");

    // R2, R3, R1 on line 5 (port 0)
    pins[5] = 1'b1;
    steps(2);
    rd(3'd4, '0, "R2 no flag before third edge");
    step();
    rd(3'd4, 32'h0000_0020, "R3 rising edge flag on third edge");
    wr(3'd3, 32'h0000_0020);
    chk(irq == 2'b01, "R1 line 5 drives port 0", 32'(irq), 32'h1);
    wr(3'd4, '0);
    rd(3'd4, 32'h0000_0020, "R9 write 0 keeps flag");
    wr(3'd4, 32'h0000_0020);
    rd(3'd4, '0, "R9 write 1 clears flag");
    chk(irq == 2'b00, "R8 irq drops after clear", 32'(irq), 0);

    // R4 on line 21 (port 1)
    wr(3'd2, 32'hFFDF_FFFF);
    pins[21] = 1'b1;
    steps(4);
    rd(3'd4, '0, "R4 rise ignored with polarity 0");
    pins[21] = 1'b0;
    steps(3);
    rd(3'd4, 32'h0020_0000, "R4 falling edge flag");
    chk(irq == 2'b00, "R7 flag set but masked", 32'(irq), 0);
    wr(3'd3, 32'h0020_0000);
    chk(irq == 2'b10, "R1 line 21 drives port 1", 32'(irq), 32'h2);
    wr(3'd4, 32'h0020_0000);

    // R5 on line 9, polarity 1
    wr(3'd1, 32'h0000_0200);
    pins[9] = 1'b1;
    steps(3);
    rd(3'd4, 32'h0000_0200, "R5 both-edge rise");
    wr(3'd4, 32'h0000_0200);
    pins[9] = 1'b0;
    steps(3);
    rd(3'd4, 32'h0000_0200, "R5 both-edge fall despite polarity 1");
    wr(3'd4, 32'h0000_0200);

    // R6 level high on line 30
    wr(3'd0, 32'hBFFF_FFFF);
    step();
    rd(3'd4, '0, "R6 inactive level no flag");
    pins[30] = 1'b1;
    steps(3);
    rd(3'd4, 32'h4000_0000, "R6 high level flag");
    wr(3'd4, 32'h4000_0000);
    rd(3'd4, 32'h4000_0000, "R6 clear ineffective while level holds");
    pins[30] = 1'b0;
    steps(3);
    wr(3'd4, 32'h4000_0000);
    rd(3'd4, '0, "R6 clear after level gone");

    // R10: clear coincides with a new edge on line 5
    pins[5] = 1'b0;
    steps(3);
    rd(3'd4, '0, "R3 fall ignored in rising mode");
    pins[5] = 1'b1;
    steps(2);
    wr(3'd4, 32'h0000_0020);
    rd(3'd4, 32'h0000_0020, "R10 event beats same-cycle clear");
    wr(3'd4, 32'h0000_0020);

    // R11: unmapped write ignored, readback
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, '0, "R11 unmapped reads zero");
    rd(3'd0, 32'hBFFF_FFFF, "R11 mode readback");
    rd(3'd1, 32'h0000_0200, "R11 both readback");
    rd(3'd2, 32'hFFDF_FFFF, "R11 polarity readback");
    rd(3'd3, 32'h0020_0000, "R11 enable readback");

    // random phase, compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      pins      = $urandom();
      cfg_wr    = ($urandom_range(3) == 0);
      cfg_addr  = 3'($urandom_range(7));
      cfg_wdata = $urandom();
      step();
    end
    cfg_wr = 1'b0;

    summary();
    $finish;
  end
endmodule